// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a large set of level-sensitive interrupt inputs into groups of eight and drives one interrupt line per group toward a parent interrupt controller. A group line is high while any of its enabled inputs is active. Per-input enable bits are held inside the block. Software changes them only through two separate addresses: a write-one-to-set address and a write-one-to-clear address. Because of this, no read-modify-write sequence is needed and two agents can never race on the same bank.

Four groups share one 32-bit register bank, and each group sits in its own byte lane. Each bank exposes the enable state and a pending-status view: an input is pending when its raw level is high and it is enabled. The number of groups is a parameter, with a default of 20 groups (160 inputs in five banks). The register port is a simple single-cycle request interface. Write data takes effect at the request edge. Read data is registered and appears after that edge.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `grp_irq_o` bit is 0 and `bus_rdata_o` is 0.
- R2: A write to bank offset 0x0 sets every enable bit whose data bit is 1 and leaves the others unchanged; a read of offset 0x0 returns the bank's 32 enable bits.
- R3: A write to bank offset 0x4 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R4: Bank b is at byte address b*0x10 (address bits [ADDR_W-1:4] select the bank, bits [3:2] the register). Group g uses bank g/4 and bits 8*(g%4) to 8*(g%4)+7 of it. Input `irq_i[g*8+k]` is bit 8*(g%4)+k of that bank.
- R5: A read of bank offset 0xC returns, for each bit, the input level ANDed with its enable bit; writes to 0xC change nothing.
- R6: `grp_irq_o[g]` equals the OR of group g's enabled active inputs as they stood at the previous clock edge (one register stage).
- R7: Writes to offset 0x8 or to a bank at or above the bank count change no enable bit; reads of offset 0x4, offset 0x8 or such a bank return 0.
- R8: Read data is registered: it appears on `bus_rdata_o` after the edge that samples the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_i | input | NUM_GROUPS*8 | Level-sensitive interrupt inputs, flat index group*8+bit |
| grp_irq_o | output | NUM_GROUPS | One registered interrupt line per group |

## Verification
The bound checker checks on every cycle that each group line follows the OR of the enabled inputs from the edge before. It also checks that set writes leave their bits set, that clear writes leave their bits clear, and that writes to the reserved offset leave all enables stable. In addition it checks that reads of status and of the reserved offset return the expected word one edge later. Only the bench scenarios show the address map: which bank and byte lane a given flat input lands in, that unmapped banks are inert, and that the random mix of set, clear and input changes gives the modelled enable and status words.

// File: rtl/combiner_pkg.sv
package combiner_pkg;
  localparam int GRP_W  = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = GRP_W * LANES;

  typedef enum logic [1:0] {
    REG_EN_SET = 2'd0,
    REG_EN_CLR = 2'd1,
    REG_RSVD   = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  function automatic int bank_count(int groups);
    return (groups + LANES - 1) / LANES;
  endfunction

  // byte lanes that hold a real group in bank b
  function automatic logic [WORD_W-1:0] lane_mask(int groups, int b);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++)
      if (b * LANES + l < groups) m[l*GRP_W +: GRP_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/combiner_reg_decode.sv
module combiner_reg_decode
  import combiner_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 8,
  localparam int BANK_W   = ADDR_W - 4
) (
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [NUM_BANKS-1:0] set_stb_o,
  output logic [NUM_BANKS-1:0] clr_stb_o,
  output logic [NUM_BANKS-1:0] rd_bank_o,
  output reg_sel_e          rd_sel_o,
  output logic              rd_stb_o
);
  logic [BANK_W-1:0] bank;
  reg_sel_e          sel;

  assign bank     = bus_addr_i[ADDR_W-1:4];
  assign sel      = reg_sel_e'(bus_addr_i[3:2]);
  assign rd_sel_o = sel;
  assign rd_stb_o = bus_en_i && !bus_we_i;

  always_comb begin
    set_stb_o = '0;
    clr_stb_o = '0;
    rd_bank_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank == BANK_W'(b)) begin
        rd_bank_o[b] = 1'b1;
        set_stb_o[b] = bus_en_i && bus_we_i && (sel == REG_EN_SET);
        clr_stb_o[b] = bus_en_i && bus_we_i && (sel == REG_EN_CLR);
      end
    end
  end
endmodule

// File: rtl/combiner_enable_bank.sv
module combiner_enable_bank
  import combiner_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_stb_i,
  input  logic              clr_stb_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] en_o
);
  logic [WORD_W-1:0] en_q, set_m, clr_m;

  assign set_m = set_stb_i ? wdata_i : '0;
  assign clr_m = clr_stb_i ? wdata_i : '0;

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_m) & ~clr_m & VALID;
  end

  assign en_o = en_q;
endmodule

// File: rtl/combiner_group_or.sv
module combiner_group_or
  import combiner_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] pend_i,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend_i;
  end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import combiner_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8,
  localparam int NUM_IN    = NUM_GROUPS * GRP_W,
  localparam int NUM_BANKS = bank_count(NUM_GROUPS),
  localparam int FLAT_W    = NUM_BANKS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NUM_IN-1:0] irq_i,
  output logic [NUM_GROUPS-1:0] grp_irq_o
);
  logic [NUM_BANKS-1:0] set_stb, clr_stb, rd_bank;
  reg_sel_e             rd_sel;
  logic                 rd_stb;
  logic [FLAT_W-1:0]    en_flat, irq_pad, status_flat;
  logic [WORD_W-1:0]    rd_word;
  logic [31:0]          rdata_q;

  combiner_reg_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
    .bus_en_i  (bus_en_i),
    .bus_we_i  (bus_we_i),
    .bus_addr_i(bus_addr_i),
    .set_stb_o (set_stb),
    .clr_stb_o (clr_stb),
    .rd_bank_o (rd_bank),
    .rd_sel_o  (rd_sel),
    .rd_stb_o  (rd_stb)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    combiner_enable_bank #(.VALID(lane_mask(NUM_GROUPS, b))) u_en (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_stb_i(set_stb[b]),
      .clr_stb_i(clr_stb[b]),
      .wdata_i  (bus_wdata_i),
      .en_o     (en_flat[b*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    irq_pad = '0;
    irq_pad[NUM_IN-1:0] = irq_i;
  end

  assign status_flat = irq_pad & en_flat;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    combiner_group_or u_or (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pend_i(status_flat[g*GRP_W +: GRP_W]),
      .irq_o (grp_irq_o[g])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_bank[b]) begin
        unique case (rd_sel)
          REG_EN_SET: rd_word = en_flat[b*WORD_W +: WORD_W];
          REG_STATUS: rd_word = status_flat[b*WORD_W +: WORD_W];
          default:    rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_word;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/combiner_checker.sv
module combiner_checker
  import combiner_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8,
  localparam int NUM_IN    = NUM_GROUPS * GRP_W,
  localparam int NUM_BANKS = bank_count(NUM_GROUPS),
  localparam int FLAT_W    = NUM_BANKS * WORD_W,
  localparam int BANK_W    = ADDR_W - 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic [NUM_IN-1:0] irq_i,
  input logic [NUM_GROUPS-1:0] grp_irq_o,
  input logic [FLAT_W-1:0] en_flat
);
  function automatic logic [WORD_W-1:0] word_at(logic [FLAT_W-1:0] v, logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (a[ADDR_W-1:4] == BANK_W'(b)) w = v[b*WORD_W +: WORD_W];
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] mask_at(logic [ADDR_W-1:0] a);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (a[ADDR_W-1:4] == BANK_W'(b)) m = lane_mask(NUM_GROUPS, b);
    return m;
  endfunction

  function automatic logic [NUM_GROUPS-1:0] grp_of(logic [NUM_IN-1:0] irq, logic [FLAT_W-1:0] en);
    logic [NUM_GROUPS-1:0] r;
    for (int g = 0; g < NUM_GROUPS; g++)
      r[g] = |(irq[g*GRP_W +: GRP_W] & en[g*GRP_W +: GRP_W]);
    return r;
  endfunction

  logic wr_set, wr_clr, wr_rsvd, rd_status, rd_rsvd;
  assign wr_set    = bus_en_i && bus_we_i && bus_addr_i[3:2] == 2'd0;
  assign wr_clr    = bus_en_i && bus_we_i && bus_addr_i[3:2] == 2'd1;
  assign wr_rsvd   = bus_en_i && bus_we_i && bus_addr_i[3:2] == 2'd2;
  assign rd_status = bus_en_i && !bus_we_i && bus_addr_i[3:2] == 2'd3;
  assign rd_rsvd   = bus_en_i && !bus_we_i && bus_addr_i[3:2] == 2'd2;

  assert_idle_when_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_flat == '0) |=> (grp_irq_o == '0));

  assert_set_sticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((word_at(en_flat, $past(bus_addr_i)) & $past(bus_wdata_i) & mask_at($past(bus_addr_i)))
               == ($past(bus_wdata_i) & mask_at($past(bus_addr_i)))));

  assert_clear_sticks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((word_at(en_flat, $past(bus_addr_i)) & $past(bus_wdata_i)) == '0));

  assert_status_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status |=> (bus_rdata_o == word_at({{(FLAT_W-NUM_IN){1'b0}}, $past(irq_i)} & $past(en_flat),
                                          $past(bus_addr_i))));

  assert_group_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (grp_irq_o == grp_of($past(irq_i), $past(en_flat))));

  assert_rsvd_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rsvd |=> $stable(en_flat));

  assert_rsvd_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rsvd |=> (bus_rdata_o == '0));

  assert_rdata_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_en_i && !bus_we_i) |=> $stable(bus_rdata_o));
endmodule

bind irq_group_combiner combiner_checker #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_en_i   (bus_en_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_i      (irq_i),
  .grp_irq_o  (grp_irq_o),
  .en_flat    (en_flat)
);

// File: tb/irq_group_combiner_bench.sv
`timescale 1ns/1ps
module irq_group_combiner_bench;
  localparam int NG = 20;
  localparam int NB = 5;
  localparam int AW = 8;
  localparam int NI = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic [NI-1:0] irq = '0;
  logic [NG-1:0] grp;

  logic [31:0] en_m [NB];
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_irq_group_combiner (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_i(irq), .grp_irq_o(grp)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(int b);
    return irq[b*32 +: 32] & en_m[b];
  endfunction

  function automatic logic [NG-1:0] exp_grp();
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++)
      r[g] = |(irq[g*8 +: 8] & en_m[g/4][(g%4)*8 +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] exp_read(int b, int r);
    if (b >= NB) return 32'h0;
    if (r == 0) return en_m[b];
    if (r == 3) return exp_status(b);
    return 32'h0;
  endfunction

  task automatic wr(int b, int r, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(b*16 + r*4); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    if (b < NB && r == 0) en_m[b] = en_m[b] | d;
    if (b < NB && r == 1) en_m[b] = en_m[b] & ~d;
  endtask

  task automatic rd(int b, int r, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = AW'(b*16 + r*4);
    @(posedge clk);
    #1;
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(string req, int b, int r);
    logic [31:0] d;
    rd(b, r, d);
    chk(req, d, exp_read(b, r));
  endtask

  task automatic grp_chk(string req);
    @(negedge clk);
    @(posedge clk);
    #1;
    chk(req, 32'(grp), 32'(exp_grp()));
  endtask

  task automatic set_irq(logic [NI-1:0] v);
    @(negedge clk);
    irq = v;
  endtask

  function automatic logic [NI-1:0] rand_irq();
    logic [NI-1:0] v;
    for (int i = 0; i < NI / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #(4 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) en_m[b] = '0;
    irq = {NI{1'b1}};
    repeat (3) @(posedge clk);
    #1;
    chk("R1 grp after reset", 32'(grp), 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < NB; b++) rd_chk("R1 enables zero", b, 0);
    grp_chk("R1 no group with all enables off");

    // R2 / R3 set and clear
    wr(0, 0, 32'h0000_00ff);
    rd_chk("R2 set byte0", 0, 0);
    wr(0, 0, 32'h0001_0000);
    rd_chk("R2 zeros leave bits", 0, 0);
    wr(0, 1, 32'h0000_000f);
    rd_chk("R3 clear low nibble", 0, 0);
    wr(0, 1, 32'h0000_0000);
    rd_chk("R3 zero clear no effect", 0, 0);

    // R4 mapping: flat input 37 is group 4 bit 5 -> bank 1 bit 5
    set_irq('0);
    wr(1, 0, 32'h0000_0020);
    set_irq(NI'(1) << 37);
    grp_chk("R4 input 37 drives group 4");
    chk("R4 group 4 bit", 32'(grp[4]), 32'h1);
    rd_chk("R4 status bank1 bit5", 1, 3);
    // group 7 -> bank 1 lane 3
    wr(1, 0, 32'h8000_0000);
    set_irq(NI'(1) << 63);
    grp_chk("R4 input 63 drives group 7");
    chk("R4 group 7 bit", 32'(grp[7]), 32'h1);

    // R6 one-cycle latency
    set_irq(NI'(1) << 37);
    #1;
    chk("R6 before edge unchanged", 32'(grp[7]), 32'h1);
    @(posedge clk);
    #1;
    chk("R6 after one edge", 32'(grp), 32'(exp_grp()));

    // R5 status read-only
    set_irq({NI{1'b1}});
    wr(1, 3, 32'hffff_ffff);
    rd_chk("R5 status write ignored (enables)", 1, 0);
    rd_chk("R5 status value", 1, 3);

    // R7 reserved and unmapped
    wr(2, 2, 32'hffff_ffff);
    rd_chk("R7 reserved write ignored", 2, 0);
    rd_chk("R7 reserved read zero", 2, 2);
    rd_chk("R7 clear-offset read zero", 0, 1);
    wr(5, 0, 32'hffff_ffff);
    rd_chk("R7 unmapped read zero", 5, 0);
    for (int b = 0; b < NB; b++) rd_chk("R7 unmapped write no effect", b, 0);

    // R8 read data holds
    rd(0, 0, d);
    repeat (3) @(posedge clk);
    #1;
    chk("R8 rdata holds", bus_rdata, d);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int b, r, op;
      b  = $urandom % 6;
      r  = $urandom % 4;
      op = $urandom % 4;
      if (op == 0)      wr(b, r, $urandom);
      else if (op == 1) rd_chk("R2 R3 R5 R7 random read", b, r);
      else if (op == 2) set_irq(rand_irq());
      else              grp_chk("R6 random groups");
    end
    for (int b = 0; b < NB; b++) rd_chk("R2 final enables", b, 0);
    grp_chk("R6 final groups");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule